// File: doc/BRIEF.md
# EDO DRAM Page Sequencer

This block sits between a synchronous requester and an asynchronous 1M x 4 DRAM that has extended-data-out page cycling. A requester hands over one word at a time, either a read or a write, with a 20-bit word address. The sequencer splits that address into a 10-bit row half and a 10-bit column half and presents them in turn on a shared 10-bit bus. It generates the active-low row strobe, column strobe, write enable and output enable. It also drives the 4-bit write data through a separate output bus with its own enable, which a pad ring turns into a bidirectional bus.

Once a row is opened it stays open. A later request to the same row costs only a column strobe cycle. A request to another row closes the open row, waits out the precharge time and then activates the new row. A row that stays open too long is closed on its own, so the row strobe never stays low past the part's limit. Every write is issued as an early write: write enable goes low a full cycle before the column strobe falls, and the part keeps its own data pins off. All timing is set by cycle-count parameters. The defaults are sized for a 100 MHz clock.

Top module: `edo_page_seq`

## Requirements
- R1: After reset `ram_ras_n`, `ram_cas_n`, `ram_we_n` and `ram_oe_n` are 1, `ram_dq_oe` and `rd_valid` are 0, and `req_ready` is 1.
- R2: Requests are carried out in acceptance order, each with exactly one column strobe fall. At the row strobe fall `ram_addr` holds address bits [19:10], and at the column strobe fall it holds bits [9:0].
- R3: At least RCD_CYC cycles pass from the row strobe falling to the column strobe falling.
- R4: The row strobe stays low for at least RAS_MIN_CYC cycles, and stays high for at least RP_CYC cycles before it falls again.
- R5: A write is an early write. `ram_we_n` is already 0 in the cycle before the column strobe falls and is still 0 when it falls. While the strobe is low for a write, `ram_oe_n` is 1, `ram_dq_oe` is 1 and `ram_dq_out` carries the request's data.
- R6: A read holds `ram_we_n`=1, `ram_oe_n`=0 and `ram_dq_oe`=0 while the column strobe is low. It returns the value present on `ram_dq_in` in the last cycle of that low phase on `rd_data`, with a one-cycle `rd_valid` pulse the cycle after. There is one pulse per read.
- R7: Consecutive accesses to the same row are served without the row strobe rising between them. The one exception is a row that has been open for more than RAS_MAX_CYC-CAS_LO_CYC-CAS_HI_CYC-4 cycles, which may be closed first.
- R8: An access whose row differs from the previous access's row is preceded by a rise of the row strobe and a new activation.
- R9: The row strobe never stays low for more than RAS_MAX_CYC cycles, even without requests, so an idle sequencer returns to the row strobe high.
- R10: The column strobe stays low at least CAS_LO_CYC cycles and high at least CAS_HI_CYC cycles between page cycles.
- R11: A read returns the data of the last write to the same address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request taken on a cycle with valid and ready |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 20 | Word address, row in [19:10], column in [9:0] |
| req_wdata | input | 4 | Write data |
| rd_valid | output | 1 | One-cycle read data strobe |
| rd_data | output | 4 | Read data |
| ram_ras_n | output | 1 | Row strobe, active low |
| ram_cas_n | output | 1 | Column strobe, active low |
| ram_we_n | output | 1 | Write enable, active low |
| ram_oe_n | output | 1 | Output enable, active low |
| ram_addr | output | 10 | Multiplexed row/column address |
| ram_dq_out | output | 4 | Write data toward the memory |
| ram_dq_oe | output | 1 | Enable for the write data drivers |
| ram_dq_in | input | 4 | Data returned by the memory |

## Verification
The assertions assume that the memory drives `ram_dq_in` with stable, valid data by the last cycle of a read's column strobe low phase. They also assume that request fields do not change while `req_valid` is high and `req_ready` is low. The bench's memory model puts its data on the bus half a cycle after the column strobe falls and releases it when the output enable or the row strobe rises. The driver holds each request steady until it is taken. Random traffic draws rows from a small pool, so page hits, misses and long runs of hits that reach the open-row age limit all occur. The row limit is lowered to 60 cycles so that limit is actually reached.

// File: rtl/edo_pkg.sv
package edo_pkg;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_RSET,
        ST_ACT,
        ST_CSET,
        ST_CSTB,
        ST_CPRE,
        ST_OPEN,
        ST_CLOSE,
        ST_PRE
    } seq_st_e;

    function automatic int unsigned max2(int unsigned a, int unsigned b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/edo_timer.sv
module edo_timer #(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_val,
    output logic         done
);
    logic [W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (load)
            cnt_d = load_val;
        else if (cnt_q != '0)
            cnt_d = cnt_q - 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign done = (cnt_q == '0);

endmodule

// File: rtl/edo_row_track.sv
module edo_row_track #(
    parameter int ROW_W       = 10,
    parameter int AGE_W       = 16,
    parameter int RAS_MIN_CYC = 5,
    parameter int RAS_MAX_CYC = 20000,
    parameter int OPEN_LIM    = 19990
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ras_n,
    input  logic             load,
    input  logic [ROW_W-1:0] row_in,
    input  logic [ROW_W-1:0] cmp_row,
    output logic             hit,
    output logic             stale,
    output logic             min_met,
    output logic [AGE_W-1:0] age
);
    localparam logic [AGE_W-1:0] AGE_TOP = {AGE_W{1'b1}};

    typedef struct packed {
        logic [ROW_W-1:0] row;
        logic [AGE_W-1:0] age;
    } trk_t;

    trk_t d, q;

    always_comb begin
        d = q;
        if (load) d.row = row_in;
        if (ras_n)
            d.age = '0;
        else if (q.age != AGE_TOP)
            d.age = q.age + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign hit     = (q.row == cmp_row);
    assign stale   = (int'(q.age) > OPEN_LIM);
    assign min_met = (int'(q.age) >= RAS_MIN_CYC - 1);
    assign age     = q.age;

    // R9
    ras_max_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !ras_n |-> (int'(q.age) < RAS_MAX_CYC));

    // R4
    ras_min_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ras_n) |-> (int'(q.age) >= RAS_MIN_CYC));

endmodule

// File: rtl/edo_page_seq.sv
module edo_page_seq #(
    parameter int ROW_W       = 10,
    parameter int COL_W       = 10,
    parameter int DQ_W        = 4,
    parameter int RCD_CYC     = 2,
    parameter int RAS_MIN_CYC = 5,
    parameter int RP_CYC      = 4,
    parameter int CAS_LO_CYC  = 2,
    parameter int CAS_HI_CYC  = 1,
    parameter int RAS_MAX_CYC = 20000
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   req_valid,
    output logic                   req_ready,
    input  logic                   req_write,
    input  logic [ROW_W+COL_W-1:0] req_addr,
    input  logic [DQ_W-1:0]        req_wdata,
    output logic                   rd_valid,
    output logic [DQ_W-1:0]        rd_data,
    output logic                   ram_ras_n,
    output logic                   ram_cas_n,
    output logic                   ram_we_n,
    output logic                   ram_oe_n,
    output logic [((ROW_W > COL_W) ? ROW_W : COL_W)-1:0] ram_addr,
    output logic [DQ_W-1:0]        ram_dq_out,
    output logic                   ram_dq_oe,
    input  logic [DQ_W-1:0]        ram_dq_in
);
    import edo_pkg::*;

    localparam int ADDR_W   = ROW_W + COL_W;
    localparam int MUX_W    = (ROW_W > COL_W) ? ROW_W : COL_W;
    localparam int ACT_CYC  = (RCD_CYC > 1) ? RCD_CYC - 1 : 1;
    localparam int MAXC     = max2(max2(ACT_CYC, RP_CYC), max2(CAS_LO_CYC, CAS_HI_CYC));
    localparam int TW       = $clog2(MAXC + 1);
    localparam int AGE_W    = $clog2(RAS_MAX_CYC + 2);
    localparam int OPEN_LIM = RAS_MAX_CYC - CAS_LO_CYC - CAS_HI_CYC - 4;

    typedef struct packed {
        seq_st_e           st;
        logic              ras_n;
        logic              cas_n;
        logic              we_n;
        logic              oe_n;
        logic [MUX_W-1:0]  addr;
        logic              dq_oe;
        logic [DQ_W-1:0]   dq;
        logic              rd_vld;
        logic [DQ_W-1:0]   rd_data;
        logic              pend;
        logic              pw;
        logic [ADDR_W-1:0] pa;
        logic [DQ_W-1:0]   pd;
    } ctl_t;

    localparam ctl_t CTL_RST = '{
        st: ST_IDLE, ras_n: 1'b1, cas_n: 1'b1, we_n: 1'b1, oe_n: 1'b1,
        addr: '0, dq_oe: 1'b0, dq: '0, rd_vld: 1'b0, rd_data: '0,
        pend: 1'b0, pw: 1'b0, pa: '0, pd: '0};

    ctl_t d, q;

    logic           tmr_load;
    logic [TW-1:0]  tmr_val;
    logic           tmr_done;
    logic           trk_load;
    logic           row_hit;
    logic           row_stale;
    logic           row_min_met;
    logic [AGE_W-1:0] row_age;

    function automatic logic [MUX_W-1:0] row_of(logic [ADDR_W-1:0] a);
        return MUX_W'(a[ADDR_W-1:COL_W]);
    endfunction

    function automatic ctl_t col_phase(ctl_t s, logic w, logic [ADDR_W-1:0] a,
                                       logic [DQ_W-1:0] dat);
        ctl_t r;
        r       = s;
        r.st    = ST_CSET;
        r.addr  = MUX_W'(a[COL_W-1:0]);
        r.we_n  = ~w;
        r.oe_n  = w;
        r.dq_oe = w;
        r.dq    = dat;
        r.pw    = w;
        r.pa    = a;
        r.pd    = dat;
        return r;
    endfunction

    edo_timer #(.W(TW)) tmr_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (tmr_load),
        .load_val (tmr_val),
        .done     (tmr_done)
    );

    edo_row_track #(
        .ROW_W       (ROW_W),
        .AGE_W       (AGE_W),
        .RAS_MIN_CYC (RAS_MIN_CYC),
        .RAS_MAX_CYC (RAS_MAX_CYC),
        .OPEN_LIM    (OPEN_LIM)
    ) trk_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .ras_n   (q.ras_n),
        .load    (trk_load),
        .row_in  (q.pa[ADDR_W-1:COL_W]),
        .cmp_row (req_addr[ADDR_W-1:COL_W]),
        .hit     (row_hit),
        .stale   (row_stale),
        .min_met (row_min_met),
        .age     (row_age)
    );

    assign req_ready = (q.st == ST_IDLE) || ((q.st == ST_OPEN) && !row_stale);

    always_comb begin
        d        = q;
        d.rd_vld = 1'b0;
        tmr_load = 1'b0;
        tmr_val  = '0;
        trk_load = 1'b0;
        unique case (q.st)
            ST_IDLE: begin
                if (req_valid) begin
                    d.pw   = req_write;
                    d.pa   = req_addr;
                    d.pd   = req_wdata;
                    d.addr = row_of(req_addr);
                    d.st   = ST_RSET;
                end
            end
            ST_RSET: begin
                trk_load = 1'b1;
                d.ras_n  = 1'b0;
                d.st     = ST_ACT;
                tmr_load = 1'b1;
                tmr_val  = TW'(ACT_CYC - 1);
            end
            ST_ACT: begin
                if (tmr_done) d = col_phase(q, q.pw, q.pa, q.pd);
            end
            ST_CSET: begin
                d.cas_n  = 1'b0;
                d.st     = ST_CSTB;
                tmr_load = 1'b1;
                tmr_val  = TW'(CAS_LO_CYC - 1);
            end
            ST_CSTB: begin
                if (tmr_done) begin
                    d.cas_n  = 1'b1;
                    d.we_n   = 1'b1;
                    d.oe_n   = 1'b1;
                    d.dq_oe  = 1'b0;
                    d.rd_vld = ~q.pw;
                    if (!q.pw) d.rd_data = ram_dq_in;
                    d.st     = ST_CPRE;
                    tmr_load = 1'b1;
                    tmr_val  = TW'(CAS_HI_CYC - 1);
                end
            end
            ST_CPRE: begin
                if (tmr_done) d.st = ST_OPEN;
            end
            ST_OPEN: begin
                if (row_stale) begin
                    d.st = ST_CLOSE;
                end else if (req_valid) begin
                    if (row_hit) begin
                        d = col_phase(q, req_write, req_addr, req_wdata);
                    end else begin
                        d.pw   = req_write;
                        d.pa   = req_addr;
                        d.pd   = req_wdata;
                        d.pend = 1'b1;
                        d.st   = ST_CLOSE;
                    end
                end
            end
            ST_CLOSE: begin
                if (row_min_met) begin
                    d.ras_n  = 1'b1;
                    d.st     = ST_PRE;
                    tmr_load = 1'b1;
                    tmr_val  = TW'(RP_CYC - 1);
                end
            end
            ST_PRE: begin
                if (tmr_done) begin
                    if (q.pend) begin
                        d.pend = 1'b0;
                        d.addr = row_of(q.pa);
                        d.st   = ST_RSET;
                    end else begin
                        d.st   = ST_IDLE;
                    end
                end
            end
            default: d = CTL_RST;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= CTL_RST;
        else        q <= d;
    end

    assign ram_ras_n  = q.ras_n;
    assign ram_cas_n  = q.cas_n;
    assign ram_we_n   = q.we_n;
    assign ram_oe_n   = q.oe_n;
    assign ram_addr   = q.addr;
    assign ram_dq_out = q.dq;
    assign ram_dq_oe  = q.dq_oe;
    assign rd_valid   = q.rd_vld;
    assign rd_data    = q.rd_data;

    // R3
    rcd_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(q.cas_n) |-> (int'(row_age) >= RCD_CYC));

    // R7
    cas_in_row_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !q.cas_n |-> !q.ras_n);

    // R5
    early_we_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(q.cas_n) && !q.we_n) |-> ($past(q.we_n) == 1'b0));

    // R5
    wr_bus_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!q.cas_n && !q.we_n) |-> (q.dq_oe && q.oe_n));

    // R6
    rd_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        q.rd_vld |-> ($past(!q.cas_n && q.we_n && !q.oe_n && !q.dq_oe) && !$past(q.rd_vld)));

endmodule

// File: tb/edo_page_seq_tb_top.sv
module edo_page_seq_tb_top;

    localparam int RCD     = 2;
    localparam int RAS_MIN = 5;
    localparam int RP      = 4;
    localparam int CL      = 2;
    localparam int CH      = 1;
    localparam int RAS_MAX = 60;
    localparam int LIM     = RAS_MAX - CL - CH - 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic        req_write = 1'b0;
    logic [19:0] req_addr = '0;
    logic [3:0]  req_wdata = '0;
    logic        rd_valid;
    logic [3:0]  rd_data;
    logic        ram_ras_n, ram_cas_n, ram_we_n, ram_oe_n, ram_dq_oe;
    logic [9:0]  ram_addr;
    logic [3:0]  ram_dq_out;
    logic [3:0]  ram_dq_in;

    always #4 clk = ~clk;

    edo_page_seq #(.RAS_MAX_CYC(RAS_MAX)) dut_i (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
        .req_addr(req_addr), .req_wdata(req_wdata),
        .rd_valid(rd_valid), .rd_data(rd_data),
        .ram_ras_n(ram_ras_n), .ram_cas_n(ram_cas_n), .ram_we_n(ram_we_n),
        .ram_oe_n(ram_oe_n), .ram_addr(ram_addr), .ram_dq_out(ram_dq_out),
        .ram_dq_oe(ram_dq_oe), .ram_dq_in(ram_dq_in)
    );

    int n_chk = 0;
    int n_fail = 0;
    bit done_flag = 0;

    logic [3:0] ref_mem [int];
    logic [3:0] mod_mem [int];
    logic [24:0] exp_q [$];
    logic [3:0]  rdexp_q [$];

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic logic [3:0] ref_rd(input int a);
        return ref_mem.exists(a) ? ref_mem[a] : 4'h0;
    endfunction

    function automatic logic [3:0] mod_rd(input int a);
        return mod_mem.exists(a) ? mod_mem[a] : 4'h0;
    endfunction

    // memory model and protocol monitor, sampled at the falling clock edge
    logic       drive = 1'b0;
    logic [3:0] dout = '0;
    assign ram_dq_in = drive ? dout : 4'h0;

    logic p_ras = 1'b1, p_cas = 1'b1, p_we = 1'b1, p_oe = 1'b1;
    int ras_lo = 0, ras_hi = 100, cas_lo = 0, cas_hi = 100;
    int cur_row = 0, prev_row = -1, last_low = 0;
    bit rose_flag = 0;

    always @(negedge clk) begin
        if (rst_n && !done_flag) begin
            if (!ram_ras_n && p_ras) begin
                chk(ras_hi >= RP, "R4 precharge", ras_hi, RP);
                cur_row = int'(ram_addr);
                ras_lo = 1;
            end else if (!ram_ras_n) ras_lo++;
            if (ram_ras_n && !p_ras) begin
                chk(ras_lo >= RAS_MIN, "R4 ras low", ras_lo, RAS_MIN);
                chk(ras_lo <= RAS_MAX, "R9 ras max", ras_lo, RAS_MAX);
                rose_flag = 1;
                last_low = ras_lo;
                ras_hi = 1;
            end else if (ram_ras_n) ras_hi++;

            if (!ram_cas_n && p_cas) begin
                logic [24:0] e;
                int a;
                chk(!ram_ras_n, "R7 cas inside row", ram_ras_n, 0);
                chk(ras_lo - 1 >= RCD, "R3 rcd", ras_lo - 1, RCD);
                chk(cas_hi >= CH, "R10 cas high", cas_hi, CH);
                a = cur_row * 1024 + int'(ram_addr);
                if (exp_q.size() == 0) begin
                    chk(0, "R2 unexpected access", a, 0);
                end else begin
                    e = exp_q.pop_front();
                    chk(a == int'(e[23:4]), "R2 address", a, int'(e[23:4]));
                    if (e[24]) begin
                        chk(!p_we && !ram_we_n, "R5 early we", {p_we, ram_we_n}, 0);
                        chk(ram_oe_n && ram_dq_oe, "R5 bus", {ram_oe_n, ram_dq_oe}, 3);
                        chk(ram_dq_out == e[3:0], "R5 data", ram_dq_out, e[3:0]);
                        mod_mem[a] = ram_dq_out;
                    end else begin
                        chk(ram_we_n && !ram_oe_n && !ram_dq_oe, "R6 read ctl",
                            {ram_we_n, ram_oe_n, ram_dq_oe}, 4);
                        drive = 1'b1;
                        dout = mod_rd(a);
                    end
                end
                if (prev_row == cur_row) begin
                    if (rose_flag) chk(last_low > LIM, "R7 page kept open", last_low, LIM + 1);
                    else           chk(1, "R7", 0, 0);
                end else if (prev_row >= 0) begin
                    chk(rose_flag, "R8 reopen on miss", rose_flag, 1);
                end
                prev_row = cur_row;
                rose_flag = 0;
                cas_lo = 1;
            end else if (!ram_cas_n) cas_lo++;
            if (ram_cas_n && !p_cas) begin
                chk(cas_lo >= CL, "R10 cas low", cas_lo, CL);
                cas_hi = 1;
            end else if (ram_cas_n) cas_hi++;

            if ((ram_oe_n && !p_oe) || ram_ras_n) drive = 1'b0;

            if (rd_valid) begin
                if (rdexp_q.size() == 0) chk(0, "R6 extra rd_valid", 1, 0);
                else begin
                    logic [3:0] x;
                    x = rdexp_q.pop_front();
                    chk(rd_data == x, "R11 read data", rd_data, x);
                end
            end
            p_ras = ram_ras_n; p_cas = ram_cas_n; p_we = ram_we_n; p_oe = ram_oe_n;
        end
    end

    task automatic send(input bit w, input logic [19:0] a, input logic [3:0] dat);
        @(negedge clk);
        req_valid = 1'b1; req_write = w; req_addr = a; req_wdata = dat;
        while (!req_ready) @(negedge clk);
        exp_q.push_back({w, a, dat});
        if (w) ref_mem[int'(a)] = dat;
        else   rdexp_q.push_back(ref_rd(int'(a)));
        @(posedge clk);
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    task automatic finish_run();
        if (!done_flag) begin
            done_flag = 1;
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    endtask

    int cyc = 0;
    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000 && !done_flag) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
            finish_run();
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        // R1 reset state
        chk(ram_ras_n && ram_cas_n && ram_we_n && ram_oe_n, "R1 strobes",
            {ram_ras_n, ram_cas_n, ram_we_n, ram_oe_n}, 15);
        chk(!ram_dq_oe && !rd_valid && req_ready, "R1 bus/ready",
            {ram_dq_oe, rd_valid, req_ready}, 1);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        // directed corners: lowest and highest addresses, hit then miss
        send(1, 20'h00000, 4'hA);
        send(0, 20'h00000, 4'h0);
        send(1, 20'hFFFFF, 4'h5);
        send(0, 20'hFFFFF, 4'h0);
        send(0, 20'h00000, 4'h0);
        // long same-row run, longer than the open-row limit
        for (int i = 0; i < 24; i++) send(1, {10'd7, 10'(i)}, 4'(i * 3));
        for (int i = 0; i < 24; i++) send(0, {10'd7, 10'(i)}, 4'h0);
        // idle: row must close by itself (R9)
        repeat (RAS_MAX + 20) @(negedge clk);
        chk(ram_ras_n, "R9 idle close", ram_ras_n, 1);

        for (int i = 0; i < 500; i++) begin
            logic [9:0] r;
            int sel;
            sel = $urandom % 4;
            r = (sel == 0) ? 10'd0 : (sel == 1) ? 10'd7 : (sel == 2) ? 10'h3FF : 10'($urandom % 1024);
            send($urandom % 2, {r, 10'($urandom % 16)}, 4'($urandom));
            if ($urandom % 40 == 0) repeat (RAS_MAX + 10) @(negedge clk);
            else repeat ($urandom % 4) @(negedge clk);
        end

        repeat (RAS_MAX + 20) @(negedge clk);
        chk(exp_q.size() == 0, "R2 all requests issued", exp_q.size(), 0);
        chk(rdexp_q.size() == 0, "R6 all reads returned", rdexp_q.size(), 0);
        chk(ram_ras_n, "R9 final idle", ram_ras_n, 1);
        finish_run();
    end

endmodule